// File: doc/BRIEF.md
# Switch Override and Reset Controller

This block sits in a board controller and stands between eight physical 8-bit configuration switches and the logic that reads them at reset. Software reaches it through a simple byte-wide register port. Each switch has two registers. One is a shadow byte that holds a software value. The other is an enable byte that picks, bit by bit, whether the shadow or the physical switch bit is used. The switch pins pass through a two-flop synchronizer before they are used.

Two register writes can start a board reset. The first is a plain hard reset. It captures the synchronized physical switch values and ignores every enable bit. The second is a sequenced reset. It starts on a 0-to-1 change of a control bit and captures the merged, overridden values. Either trigger loads the captured configuration into output latches and drives a reset pulse of fixed length. The block also holds a 24-bit system clock frequency word and a select bit that tells the clock logic to use that word.

Top module: `swovr_ctrl`

## Requirements
- R1: After power-on reset, every shadow, enable, clock byte, sequence control and clock select register reads 0. `board_rst` is low, and `cfg_out`, `sysclk_word` and `sysclk_sel` are 0.
- R2: Switch n has its shadow byte at offset 0x20+2n and its enable byte at 0x21+2n. A read returns the stored byte, never the merged value.
- R3: After a sequenced reset, bit k of `cfg_out` equals the shadow bit when enable bit k is 1, and the synchronized physical bit when enable bit k is 0. Switch n occupies `cfg_out[8n+7:8n]`.
- R4: A write of any data to offset 0x00 while no pulse is running does two things at that clock edge. It loads the synchronized physical switches into `cfg_out`, ignoring all enables, and it raises `board_rst` from the following cycle. Offset 0x00 reads 0.
- R5: Bit 0 of offset 0x01 is the sequence control bit, and it reads back as stored. Writing 1 while the stored bit is 0 and no pulse is running starts a sequenced reset. Writing 1 while the stored bit is already 1 starts nothing.
- R6: `board_rst` stays high for exactly RST_CYC consecutive cycles, and `cfg_out` does not change while it is high.
- R7: A trigger written while `board_rst` is high neither lengthens the pulse nor changes `cfg_out`. A write to the control bit is still stored.
- R8: The clock word bytes sit at offsets 0x04, 0x05 and 0x06 and drive `sysclk_word` bits 23:16, 15:8 and 7:0 in that order. Bit 0 of offset 0x02 drives `sysclk_sel`; the other bits of 0x02 are not stored and read 0.
- R9: A change on `phys_sw` reaches the captured value only after two clock edges. A trigger at the first edge after the change captures the old value.
- R10: Offsets outside the map read 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | ADDR_W | Register offset |
| bus_wr | input | 1 | Write strobe, one byte per cycle |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for `bus_addr`, combinational |
| phys_sw | input | NUM_SW*DATA_W | Asynchronous physical switch pins, switch n at bits 8n+7:8n |
| cfg_out | output | NUM_SW*DATA_W | Configuration captured at the last reset trigger |
| board_rst | output | 1 | Board reset pulse, active high |
| sysclk_word | output | CLK_BYTES*DATA_W | Programmed system clock frequency word |
| sysclk_sel | output | 1 | Selects the programmed clock word |

## Verification
A wrong shadow or enable bit does not show on `cfg_out` until the next trigger edge. It shows on the register port at once, so readback sweeps are paired with trigger-and-compare runs over several mixes of physical, shadow and enable patterns. A wrong pulse counter shows as a pulse that is too short or too long, or as a pulse that a mid-pulse trigger stretches. Each pulse is therefore measured in cycles. A stale sequence control bit shows as a missing reset, or as an extra one, on the write right after it. A synchronizer stage that is missing or extra shifts by one cycle the point at which a switch change first becomes visible.

// File: rtl/swovr_pkg.sv
package swovr_pkg;
    // Register offsets; the switch region holds a shadow/enable byte pair per switch
    localparam int OFF_HARD_RST = 0;
    localparam int OFF_SEQ_CTRL = 1;
    localparam int OFF_CLK_EN   = 2;
    localparam int OFF_CLK_WORD = 4;
    localparam int OFF_SW_BASE  = 32;
endpackage

// File: rtl/swovr_sync.sv
module swovr_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_t;

    sync_t sync_d, sync_q;

    always_comb begin
        sync_d.s1 = async_in;
        sync_d.s2 = sync_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= sync_d;
    end

    assign sync_out = sync_q.s2;
endmodule

// File: rtl/swovr_merge.sv
module swovr_merge #(
    parameter int NUM = 8,
    parameter int W   = 8
) (
    input  logic [NUM*W-1:0] phys,
    input  logic [NUM*W-1:0] shadow,
    input  logic [NUM*W-1:0] enable,
    output logic [NUM*W-1:0] merged
);
    for (genvar g = 0; g < NUM; g++) begin : g_sw
        // per bit: enable high takes the shadow, low takes the pin
        assign merged[g*W +: W] = (enable[g*W +: W] & shadow[g*W +: W])
                                | (~enable[g*W +: W] & phys[g*W +: W]);
    end
endmodule

// File: rtl/swovr_pulse.sv
module swovr_pulse #(
    parameter int LEN   = 16,
    parameter int CNT_W = $clog2(LEN + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trig,
    output logic active
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (cnt_q != '0)  cnt_d = cnt_q - 1'b1;
        else if (trig)    cnt_d = CNT_W'(LEN);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign active = (cnt_q != '0);
endmodule

// File: rtl/swovr_ctrl.sv
module swovr_ctrl
    import swovr_pkg::*;
#(
    parameter int NUM_SW    = 8,
    parameter int DATA_W    = 8,
    parameter int ADDR_W    = 6,
    parameter int RST_CYC   = 16,
    parameter int CLK_BYTES = 3
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [ADDR_W-1:0]           bus_addr,
    input  logic                        bus_wr,
    input  logic [DATA_W-1:0]           bus_wdata,
    output logic [DATA_W-1:0]           bus_rdata,
    input  logic [NUM_SW*DATA_W-1:0]    phys_sw,
    output logic [NUM_SW*DATA_W-1:0]    cfg_out,
    output logic                        board_rst,
    output logic [CLK_BYTES*DATA_W-1:0] sysclk_word,
    output logic                        sysclk_sel
);
    localparam int CFG_W  = NUM_SW * DATA_W;
    localparam int SW_SPAN = 2 * NUM_SW;

    typedef struct packed {
        logic [NUM_SW-1:0][DATA_W-1:0]    shadow;
        logic [NUM_SW-1:0][DATA_W-1:0]    enable;
        logic [CLK_BYTES-1:0][DATA_W-1:0] clk_byte;
        logic                             seq_bit;
        logic                             clk_en;
        logic [CFG_W-1:0]                 cfg;
    } regs_t;

    regs_t             st_d, st_q;
    logic [CFG_W-1:0]  phys_s;
    logic [CFG_W-1:0]  merged;
    logic              busy;
    logic              fire;
    logic [ADDR_W-1:0] rel;
    logic              in_sw;
    logic              seq_bit_q;

    swovr_sync #(.W(CFG_W)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (phys_sw),
        .sync_out (phys_s)
    );

    swovr_merge #(.NUM(NUM_SW), .W(DATA_W)) u_merge (
        .phys   (phys_s),
        .shadow (st_q.shadow),
        .enable (st_q.enable),
        .merged (merged)
    );

    swovr_pulse #(.LEN(RST_CYC)) u_pulse (
        .clk    (clk),
        .rst_n  (rst_n),
        .trig   (fire),
        .active (busy)
    );

    always_comb begin
        st_d      = st_q;
        fire      = 1'b0;
        bus_rdata = '0;
        rel       = bus_addr - ADDR_W'(OFF_SW_BASE);
        in_sw     = (bus_addr >= ADDR_W'(OFF_SW_BASE)) && (rel < ADDR_W'(SW_SPAN));

        // register writes and trigger decode
        if (bus_wr) begin
            if (bus_addr == ADDR_W'(OFF_HARD_RST) && !busy) begin
                fire    = 1'b1;
                st_d.cfg = phys_s;
            end
            if (bus_addr == ADDR_W'(OFF_SEQ_CTRL)) begin
                st_d.seq_bit = bus_wdata[0];
                if (bus_wdata[0] && !st_q.seq_bit && !busy) begin
                    fire     = 1'b1;
                    st_d.cfg = merged;
                end
            end
            if (bus_addr == ADDR_W'(OFF_CLK_EN)) st_d.clk_en = bus_wdata[0];
            for (int b = 0; b < CLK_BYTES; b++) begin
                if (bus_addr == ADDR_W'(OFF_CLK_WORD + b)) st_d.clk_byte[b] = bus_wdata;
            end
            for (int i = 0; i < NUM_SW; i++) begin
                if (in_sw && rel[ADDR_W-1:1] == (ADDR_W-1)'(i)) begin
                    if (rel[0]) st_d.enable[i] = bus_wdata;
                    else        st_d.shadow[i] = bus_wdata;
                end
            end
        end

        // read mux: stored values only
        if (bus_addr == ADDR_W'(OFF_SEQ_CTRL))
            bus_rdata = {{(DATA_W-1){1'b0}}, st_q.seq_bit};
        if (bus_addr == ADDR_W'(OFF_CLK_EN))
            bus_rdata = {{(DATA_W-1){1'b0}}, st_q.clk_en};
        for (int b = 0; b < CLK_BYTES; b++) begin
            if (bus_addr == ADDR_W'(OFF_CLK_WORD + b)) bus_rdata = st_q.clk_byte[b];
        end
        for (int i = 0; i < NUM_SW; i++) begin
            if (in_sw && rel[ADDR_W-1:1] == (ADDR_W-1)'(i))
                bus_rdata = rel[0] ? st_q.enable[i] : st_q.shadow[i];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // byte 0 carries the most significant bits of the clock word
    for (genvar gb = 0; gb < CLK_BYTES; gb++) begin : g_clkw
        assign sysclk_word[(CLK_BYTES-1-gb)*DATA_W +: DATA_W] = st_q.clk_byte[gb];
    end

    assign cfg_out    = st_q.cfg;
    assign sysclk_sel = st_q.clk_en;
    assign board_rst  = busy;
    assign seq_bit_q  = st_q.seq_bit;
endmodule

// File: rtl/swovr_chk.sv
module swovr_chk
    import swovr_pkg::*;
#(
    parameter int ADDR_W  = 6,
    parameter int DATA_W  = 8,
    parameter int CFG_W   = 64,
    parameter int CLK_W   = 24,
    parameter int RST_CYC = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              board_rst,
    input logic [CFG_W-1:0]  cfg_out,
    input logic [CLK_W-1:0]  sysclk_word,
    input logic              sysclk_sel,
    input logic              seq_bit
);
    int hi_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         hi_cnt <= 0;
        else if (board_rst) hi_cnt <= hi_cnt + 1;
        else                hi_cnt <= 0;
    end

    a_r4_hard_fire: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr && bus_addr == ADDR_W'(OFF_HARD_RST) && !board_rst |=> board_rst);

    a_r5_seq_fire: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr && bus_addr == ADDR_W'(OFF_SEQ_CTRL) && bus_wdata[0] && !seq_bit && !board_rst
        |=> board_rst);

    a_r5_seq_level: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr && bus_addr == ADDR_W'(OFF_SEQ_CTRL) && seq_bit && !board_rst |=> !board_rst);

    a_r6_pulse_len: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(board_rst) |-> hi_cnt == RST_CYC);

    a_r7_no_stretch: assert property (@(posedge clk) disable iff (!rst_n)
        board_rst |-> hi_cnt < RST_CYC);

    a_r6_cfg_hold: assert property (@(posedge clk) disable iff (!rst_n)
        board_rst && $past(board_rst) |-> $stable(cfg_out));

    a_r3_cfg_on_trigger: assert property (@(posedge clk) disable iff (!rst_n)
        !$rose(board_rst) |-> $stable(cfg_out));

    a_r8_clk_msb: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr && bus_addr == ADDR_W'(OFF_CLK_WORD) |=> sysclk_word[CLK_W-1 -: DATA_W] == $past(bus_wdata));

    a_r8_clk_sel: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr && bus_addr == ADDR_W'(OFF_CLK_EN) |=> sysclk_sel == $past(bus_wdata[0]));
endmodule

bind swovr_ctrl swovr_chk #(
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W),
    .CFG_W   (NUM_SW * DATA_W),
    .CLK_W   (CLK_BYTES * DATA_W),
    .RST_CYC (RST_CYC)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_addr    (bus_addr),
    .bus_wr      (bus_wr),
    .bus_wdata   (bus_wdata),
    .board_rst   (board_rst),
    .cfg_out     (cfg_out),
    .sysclk_word (sysclk_word),
    .sysclk_sel  (sysclk_sel),
    .seq_bit     (seq_bit_q)
);

// File: tb/swovr_ctrl_tb.sv
`timescale 1ns/1ps
module swovr_ctrl_tb;
    localparam int NSW  = 8;
    localparam int DW   = 8;
    localparam int AW   = 6;
    localparam int RCYC = 16;
    localparam int CB   = 3;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [AW-1:0]   bus_addr = '0;
    logic            bus_wr = 1'b0;
    logic [DW-1:0]   bus_wdata = '0;
    logic [DW-1:0]   bus_rdata;
    logic [NSW*DW-1:0] phys_sw = '0;
    logic [NSW*DW-1:0] cfg_out;
    logic            board_rst;
    logic [CB*DW-1:0] sysclk_word;
    logic            sysclk_sel;

    int n_chk = 0;
    int n_bad = 0;
    int run_len = 0;
    int last_len = 0;
    logic [DW-1:0] sh_m [NSW];
    logic [DW-1:0] en_m [NSW];

    always #2 clk = ~clk;

    swovr_ctrl #(.NUM_SW(NSW), .DATA_W(DW), .ADDR_W(AW), .RST_CYC(RCYC), .CLK_BYTES(CB)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .phys_sw(phys_sw),
        .cfg_out(cfg_out), .board_rst(board_rst), .sysclk_word(sysclk_word),
        .sysclk_sel(sysclk_sel)
    );

    // pulse length measured at falling edges
    always @(negedge clk) begin
        if (board_rst) run_len <= run_len + 1;
        else if (run_len != 0) begin
            last_len <= run_len;
            run_len  <= 0;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input int a, input logic [DW-1:0] d);
        @(negedge clk);
        bus_addr = AW'(a); bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd_reg(input int a, output logic [DW-1:0] d);
        @(negedge clk);
        bus_addr = AW'(a); bus_wr = 1'b0;
        #1 d = bus_rdata;
    endtask

    task automatic wait_idle();
        while (board_rst) @(negedge clk);
        repeat (2) @(negedge clk);
        #1;
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    function automatic logic [DW-1:0] pat_phys(int p, int i);
        return DW'(p * 53 + i * 71 + 9);
    endfunction
    function automatic logic [DW-1:0] pat_sh(int p, int i);
        return DW'(p * 97 + i * 13 + 64);
    endfunction
    function automatic logic [DW-1:0] pat_en(int p, int i);
        case (p)
            0: return 8'h00;
            1: return 8'hFF;
            2: return DW'(i * 37 + 11);
            default: return DW'(8'h0F << (i % 5));
        endcase
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [DW-1:0] rv;
        logic [NSW*DW-1:0] exp_cfg;
        logic [NSW*DW-1:0] held;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); #1;

        // R1 reset state
        chk(board_rst == 1'b0, "R1 board_rst", 64'(board_rst), 0);
        chk(cfg_out == '0, "R1 cfg_out", cfg_out, 0);
        chk(sysclk_word == '0 && sysclk_sel == 1'b0, "R1 clock outputs", 64'(sysclk_word), 0);
        for (int a = 0; a < (1 << AW); a++) begin
            rd_reg(a, rv);
            chk(rv == '0, $sformatf("R1 read offset %0h", a), 64'(rv), 0);
        end

        // R2 shadow/enable sweep, readback is stored not merged
        phys_sw = {NSW{8'hC3}};
        for (int i = 0; i < NSW; i++) begin
            sh_m[i] = DW'(8'h3C ^ (i * 17));
            en_m[i] = DW'(8'hA5 + i * 29);
            wr_reg(32 + 2 * i, sh_m[i]);
            wr_reg(33 + 2 * i, en_m[i]);
        end
        for (int i = 0; i < NSW; i++) begin
            rd_reg(32 + 2 * i, rv);
            chk(rv == sh_m[i], $sformatf("R2 shadow %0d", i), 64'(rv), 64'(sh_m[i]));
            rd_reg(33 + 2 * i, rv);
            chk(rv == en_m[i], $sformatf("R2 enable %0d", i), 64'(rv), 64'(en_m[i]));
        end

        // R8 clock word and select
        wr_reg(4, 8'h12); wr_reg(5, 8'h34); wr_reg(6, 8'h56);
        #1 chk(sysclk_word == 24'h123456, "R8 word order", 64'(sysclk_word), 64'h123456);
        wr_reg(2, 8'hFF);
        #1 chk(sysclk_sel == 1'b1, "R8 select", 64'(sysclk_sel), 1);
        rd_reg(2, rv);
        chk(rv == 8'h01, "R8 select readback", 64'(rv), 1);
        rd_reg(5, rv);
        chk(rv == 8'h34, "R8 middle byte", 64'(rv), 64'h34);
        wr_reg(2, 8'hFE);
        #1 chk(sysclk_sel == 1'b0, "R8 select clear", 64'(sysclk_sel), 0);

        // R10 unmapped offsets
        wr_reg(3, 8'hFF); wr_reg(7, 8'hFF); wr_reg(16, 8'hFF); wr_reg(63, 8'hFF);
        for (int a = 0; a < (1 << AW); a++) begin
            if (a == 3 || a == 7 || (a >= 8 && a < 32) || a >= 48) begin
                rd_reg(a, rv);
                chk(rv == '0, $sformatf("R10 unmapped %0h", a), 64'(rv), 0);
            end
        end
        rd_reg(32, rv);
        chk(rv == sh_m[0], "R10 shadow untouched", 64'(rv), 64'(sh_m[0]));
        #1 chk(board_rst == 1'b0, "R10 no reset", 64'(board_rst), 0);

        // R3/R5/R6 sequenced reset over several mixes
        for (int p = 0; p < 4; p++) begin
            for (int i = 0; i < NSW; i++) begin
                phys_sw[i*DW +: DW] = pat_phys(p, i);
                sh_m[i] = pat_sh(p, i);
                en_m[i] = pat_en(p, i);
                wr_reg(32 + 2 * i, sh_m[i]);
                wr_reg(33 + 2 * i, en_m[i]);
                exp_cfg[i*DW +: DW] = (en_m[i] & sh_m[i]) | (~en_m[i] & pat_phys(p, i));
            end
            wr_reg(1, 8'h00);
            repeat (3) @(negedge clk);
            wr_reg(1, 8'h01);
            #1 chk(board_rst == 1'b1, $sformatf("R5 seq fire p%0d", p), 64'(board_rst), 1);
            wait_idle();
            chk(last_len == RCYC, $sformatf("R6 pulse length p%0d", p), 64'(last_len), RCYC);
            chk(cfg_out == exp_cfg, $sformatf("R3 merge p%0d", p), cfg_out, exp_cfg);
        end

        // R5 writing 1 when already 1 does nothing
        held = cfg_out;
        wr_reg(1, 8'h01);
        repeat (3) begin
            #1 chk(board_rst == 1'b0, "R5 level no fire", 64'(board_rst), 0);
            @(negedge clk);
        end
        chk(cfg_out == held, "R5 cfg unchanged", cfg_out, held);

        // R4 hard reset ignores enables
        for (int i = 0; i < NSW; i++) phys_sw[i*DW +: DW] = DW'(i * 41 + 200);
        repeat (3) @(negedge clk);
        held = phys_sw;
        wr_reg(0, 8'h5A);
        #1 chk(board_rst == 1'b1, "R4 hard fire", 64'(board_rst), 1);
        chk(cfg_out == held, "R4 physical captured", cfg_out, held);
        wait_idle();
        chk(last_len == RCYC, "R4 pulse length", 64'(last_len), RCYC);
        rd_reg(0, rv);
        chk(rv == '0, "R4 offset 0 reads 0", 64'(rv), 0);

        // R7 triggers during a pulse are ignored
        wr_reg(1, 8'h00);
        wr_reg(0, 8'h00);
        held = cfg_out;
        phys_sw = ~phys_sw;
        repeat (3) @(negedge clk);
        wr_reg(1, 8'h01);
        wr_reg(0, 8'h00);
        #1 chk(cfg_out == held, "R7 cfg held in pulse", cfg_out, held);
        wait_idle();
        chk(last_len == RCYC, "R7 no stretch", 64'(last_len), RCYC);
        chk(cfg_out == held, "R7 cfg after pulse", cfg_out, held);
        rd_reg(1, rv);
        chk(rv == 8'h01, "R7 ctrl stored", 64'(rv), 1);

        // R9 synchronizer latency
        held = phys_sw;
        @(negedge clk);
        phys_sw = ~held;
        bus_addr = '0; bus_wdata = '0; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
        #1 chk(cfg_out == held, "R9 old value captured", cfg_out, held);
        wait_idle();
        wr_reg(0, 8'h00);
        #1 chk(cfg_out == ~held, "R9 new value after sync", cfg_out, ~held);
        wait_idle();

        finish_run();
    end
endmodule